// File: doc/BRIEF.md
# Host Interrupt Aggregator with Coalescing

This block gathers event pulses from many device sources into one status word that the host can read. Each implemented status bit latches when its event pulse arrives and stays set until the host writes a one to it. A second status word holds per-channel DMA events. Its bits are not routed to the host line one by one. They fold into three summary bits of the main word instead: receive, transmit and DMA error.

An enable mask picks which main bits may raise the single interrupt output. A coalescing delay, counted in ticks of a parameterised prescaler (one tick stands for 32 microseconds), holds the line back after the first enabled event, so later events can pile up behind one interrupt. A high-priority receive event in the DMA word skips that delay. The host reaches the four registers through a plain write-strobe and address port. Read data is combinational on the address.

Top module: `hirq_aggregator`

Register addresses: 0 main status (write 1 to clear), 1 enable mask, 2 DMA status (write 1 to clear), 3 coalescing count.

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A pulse on `src_evt` bit 28, 26, 25, 7, 6, 3, 1 or 0 sets the same main status bit on the next clock edge. Pulses on any other `src_evt` bit are ignored, and those main bits read 0.
- R3: Writing address 0 clears every direct main bit written as 1 and leaves bits written as 0 unchanged. Writes to the summary bits 31, 29 and 27 have no effect.
- R4: A pulse on `dma_evt` bit 31, 30, 17, 16, 1 or 0 sets that DMA status bit. Writing 1 to address 2 clears it. All other DMA bits read 0.
- R5: Main bit 31 reads as the OR of DMA bits 17:16, main bit 29 as DMA bit 31, and main bit 27 as the OR of DMA bits 1:0.
- R6: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R7: Address 1 stores the enable mask for main bits 31, 29, 28:25, 7:6, 3, 1 and 0, and reads back only those bits. A pending main bit whose enable is 0 never raises `irq`.
- R8: With coalescing count N > 0, `irq` rises exactly 1 + N*TICK_CYCLES edges after the edge that first made an enabled bit pending.
- R9: With a coalescing count of 0, `irq` rises on the edge after the enabled bit becomes pending.
- R10: When DMA bit 30 (high-priority receive) is set and enable bit 31 is set, `irq` is high on the next edge, whatever the coalescing count.
- R11: `irq` falls on the edge after the last enabled pending bit clears. The next enabled event then waits the full coalescing delay again.
- R12: Address 3 stores a COAL_W-bit coalescing count. Upper write bits are dropped and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 main, 1 enable, 2 DMA, 3 coalescing) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src_evt | input | 32 | One-cycle event pulses for the main status word |
| dma_evt | input | 32 | One-cycle event pulses for the DMA status word |
| irq | output | 1 | Host interrupt line |

## Verification
A status or configuration change becomes visible on `rdata` right after the edge that samples the pulse or write. The bench therefore drives on the falling edge and reads half a cycle after the next rising edge. The interrupt line is due 1 + N*TICK_CYCLES edges after the pending edge, or 1 edge after it for a count of zero or a high-priority event. It falls one edge after the clearing write. The bench counts falling edges from the stimulus and samples once one edge before each due point and once on it. In the random phase the coalescing count is held at zero, so the expected line on every cycle equals the pending state the bench model held before the previous edge.

// File: rtl/hirq_pkg.sv
`timescale 1ns/1ps
package hirq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MAIN = 2'd0,
        REG_EN   = 2'd1,
        REG_DMA  = 2'd2,
        REG_COAL = 2'd3
    } reg_sel_e;

    // summary positions in the main word
    localparam int MAIN_RX_SUM  = 31;
    localparam int MAIN_ERR_SUM = 29;
    localparam int MAIN_TX_SUM  = 27;

    // DMA word positions
    localparam int DMA_ERR   = 31;
    localparam int DMA_HIPRI = 30;
    localparam int DMA_RX_HI = 17;
    localparam int DMA_RX_LO = 16;
    localparam int DMA_TX_HI = 1;
    localparam int DMA_TX_LO = 0;

    // directly latched main sources: 28 26 25 7 6 3 1 0
    localparam logic [DATA_W-1:0] MAIN_DIRECT_MASK  = 32'h1600_00CB;
    localparam logic [DATA_W-1:0] MAIN_SUMMARY_MASK = 32'hA800_0000;
    localparam logic [DATA_W-1:0] MAIN_IMPL_MASK    = MAIN_DIRECT_MASK | MAIN_SUMMARY_MASK;
    localparam logic [DATA_W-1:0] DMA_IMPL_MASK     = 32'hC003_0003;

endpackage

// File: rtl/hirq_w1c_reg.sv
`timescale 1ns/1ps
module hirq_w1c_reg #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } w1c_t;

    w1c_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set in the same cycle as a clear keeps the bit
        st_d.bits = ((st_q.bits & ~clr_i) | set_i) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/hirq_coalesce_timer.sv
`timescale 1ns/1ps
module hirq_coalesce_timer #(
    parameter int TICK_CYCLES = 6400,
    parameter int COAL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending_i,
    input  logic              bypass_i,
    input  logic [COAL_W-1:0] coal_i,
    output logic              irq_o
);

    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic              armed;
        logic              expired;
        logic [PW-1:0]     presc;
        logic [COAL_W-1:0] ticks;
        logic              irq;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!pending_i) begin
            t_d.armed   = 1'b0;
            t_d.expired = 1'b0;
            t_d.presc   = '0;
            t_d.ticks   = '0;
        end else if (!t_q.armed) begin
            t_d.armed   = 1'b1;
            t_d.presc   = '0;
            t_d.ticks   = coal_i;
            t_d.expired = (coal_i == '0);
        end else if (!t_q.expired) begin
            if (t_q.presc == PRESC_LAST) begin
                t_d.presc = '0;
                t_d.ticks = t_q.ticks - COAL_W'(1);
                if (t_q.ticks == COAL_W'(1)) t_d.expired = 1'b1;
            end else begin
                t_d.presc = t_q.presc + PW'(1);
            end
        end
        t_d.irq = pending_i & (t_d.expired | bypass_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq_o = t_q.irq;

endmodule

// File: rtl/hirq_aggregator.sv
`timescale 1ns/1ps
module hirq_aggregator
    import hirq_pkg::*;
#(
    parameter int TICK_CYCLES = 6400,
    parameter int COAL_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] src_evt,
    input  logic [DATA_W-1:0] dma_evt,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [COAL_W-1:0] coal;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [DATA_W-1:0] main_direct;
    logic [DATA_W-1:0] dma_stat;
    logic [DATA_W-1:0] summary;
    logic [DATA_W-1:0] main_view;
    logic [DATA_W-1:0] en_reg;
    logic [DATA_W-1:0] main_clr;
    logic [DATA_W-1:0] dma_clr;
    logic              pending;
    logic              hp_req;

    assign main_clr = (wr_en && addr == REG_MAIN) ? wdata : '0;
    assign dma_clr  = (wr_en && addr == REG_DMA)  ? wdata : '0;

    hirq_w1c_reg #(.W(DATA_W), .IMPL(MAIN_DIRECT_MASK)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (src_evt),
        .clr_i (main_clr),
        .q_o   (main_direct)
    );

    hirq_w1c_reg #(.W(DATA_W), .IMPL(DMA_IMPL_MASK)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dma_evt),
        .clr_i (dma_clr),
        .q_o   (dma_stat)
    );

    // DMA word folds into three summary bits of the main word
    always_comb begin
        summary               = '0;
        summary[MAIN_RX_SUM]  = |dma_stat[DMA_RX_HI:DMA_RX_LO];
        summary[MAIN_ERR_SUM] = dma_stat[DMA_ERR];
        summary[MAIN_TX_SUM]  = |dma_stat[DMA_TX_HI:DMA_TX_LO];
    end

    assign main_view = main_direct | summary;
    assign en_reg    = cfg_q.en;
    assign hp_req    = dma_stat[DMA_HIPRI] & en_reg[MAIN_RX_SUM];
    assign pending   = (|(main_view & en_reg)) | hp_req;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && addr == REG_EN)   cfg_d.en   = wdata & MAIN_IMPL_MASK;
        if (wr_en && addr == REG_COAL) cfg_d.coal = wdata[COAL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (addr)
            REG_MAIN: rdata = main_view;
            REG_EN:   rdata = cfg_q.en;
            REG_DMA:  rdata = dma_stat;
            default:  rdata = DATA_W'(cfg_q.coal);
        endcase
    end

    hirq_coalesce_timer #(.TICK_CYCLES(TICK_CYCLES), .COAL_W(COAL_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .bypass_i  (hp_req),
        .coal_i    (cfg_q.coal),
        .irq_o     (irq)
    );

endmodule

// File: rtl/hirq_checker.sv
`timescale 1ns/1ps
module hirq_checker
    import hirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] src_evt,
    input logic [DATA_W-1:0] dma_evt,
    input logic [DATA_W-1:0] main_direct,
    input logic [DATA_W-1:0] dma_stat,
    input logic [DATA_W-1:0] en_reg,
    input logic              pending,
    input logic              irq
);

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_evt & MAIN_DIRECT_MASK)) |=>
            ((main_direct & $past(src_evt & MAIN_DIRECT_MASK)) == $past(src_evt & MAIN_DIRECT_MASK)));

    p_w1c_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_MAIN && (src_evt & MAIN_DIRECT_MASK) == '0) |=>
            ((main_direct & $past(wdata) & MAIN_DIRECT_MASK) == '0));

    p_dma_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_evt & DMA_IMPL_MASK)) |=>
            ((dma_stat & $past(dma_evt & DMA_IMPL_MASK)) == $past(dma_evt & DMA_IMPL_MASK)));

    p_hp_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_stat[DMA_HIPRI] && en_reg[MAIN_RX_SUM]) |=> irq);

    p_irq_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq);

    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(pending));

endmodule

bind hirq_aggregator hirq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .src_evt     (src_evt),
    .dma_evt     (dma_evt),
    .main_direct (main_direct),
    .dma_stat    (dma_stat),
    .en_reg      (en_reg),
    .pending     (pending),
    .irq         (irq)
);

// File: tb/tb_hirq_aggregator.sv
`timescale 1ns/1ps
module tb_hirq_aggregator;

    localparam int TICK = 8;
    localparam int CW   = 8;
    localparam logic [31:0] DIRECT = 32'h1600_00CB;
    localparam logic [31:0] SUMM   = 32'hA800_0000;
    localparam logic [31:0] DMAM   = 32'hC003_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] src_evt = '0;
    logic [31:0] dma_evt = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_main = '0, m_dma = '0, m_en = '0, m_coal = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    hirq_aggregator #(.TICK_CYCLES(TICK), .COAL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_evt(src_evt), .dma_evt(dma_evt), .irq(irq)
    );

    function automatic logic [31:0] view_main(input logic [31:0] mm, input logic [31:0] md);
        logic [31:0] v = mm;
        v[31] = md[17] | md[16];
        v[29] = md[31];
        v[27] = md[1] | md[0];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return view_main(m_main, m_dma);
            2'd1:    return m_en;
            2'd2:    return m_dma;
            default: return m_coal;
        endcase
    endfunction

    function automatic logic model_pending();
        return (|(view_main(m_main, m_dma) & m_en)) | (m_dma[30] & m_en[31]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        wr_en = 1'b0;
        addr  = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_rd(input string tag, input logic [1:0] a);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, model_read(a));
    endtask

    // one clock: drive at falling edge, model update, return after next falling edge
    task automatic step(input logic [31:0] s, input logic [31:0] dm,
                        input logic we, input logic [1:0] a, input logic [31:0] d);
        logic [31:0] cm, cd;
        src_evt = s; dma_evt = dm; wr_en = we; addr = a; wdata = d;
        m_irq = model_pending();
        cm = (we && a == 2'd0) ? d : '0;
        cd = (we && a == 2'd2) ? d : '0;
        m_main = ((m_main & ~cm) | s) & DIRECT;
        m_dma  = ((m_dma & ~cd) | dm) & DMAM;
        if (we && a == 2'd1) m_en = d & (DIRECT | SUMM);
        if (we && a == 2'd3) m_coal = {24'd0, d[7:0]};
        @(negedge clk);
        src_evt = '0; dma_evt = '0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step('0, '0, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0, 2'd0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int unused_seed;
        unused_seed = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 every source pulsed; only direct bits latch
        step(32'hFFFF_FFFF, '0, 1'b0, 2'd0, '0);
        rd(2'd0, v);
        chk("R2 direct bits latch", v, 32'h1600_00CB);

        // R3 write-one clears, zero keeps
        wr(2'd0, 32'h0000_0003);
        rd(2'd0, v);
        chk("R3 w1c clears bits 1:0", v, 32'h1600_00C8);
        wr(2'd0, 32'h0);
        chk_rd("R3 zero write keeps", 2'd0);

        // R4 DMA word latch and unimplemented bits
        step('0, 32'hFFFF_FFFF, 1'b0, 2'd0, '0);
        rd(2'd2, v);
        chk("R4 dma bits latch", v, 32'hC003_0003);
        // R5 summary bits follow DMA word
        rd(2'd0, v);
        chk("R5 summary in main", v, 32'hBE00_00C8);
        // R3 writes to summary bits have no effect
        wr(2'd0, 32'hA800_0000);
        rd(2'd0, v);
        chk("R3 summary not writable", v, 32'hBE00_00C8);
        // R5 partial clear keeps the OR
        wr(2'd2, 32'h0002_0000);
        rd(2'd0, v);
        chk("R5 rx summary with bit16 left", v[31], 1'b1);
        wr(2'd2, 32'h0001_0002);
        rd(2'd0, v);
        chk("R5 rx summary clear", {31'd0, v[31]}, 32'h0);
        chk("R5 tx summary with bit0 left", {31'd0, v[27]}, 32'h1);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd0, v);
        chk("R5 all summaries clear", v & 32'hA800_0000, 32'h0);
        chk_rd("R4 dma cleared", 2'd2);

        // R6 set beats clear on bit 0
        step(32'h1, '0, 1'b0, 2'd0, '0);
        step(32'h1, '0, 1'b1, 2'd0, 32'h1);
        rd(2'd0, v);
        chk("R6 set wins over clear", {31'd0, v[0]}, 32'h1);

        // R7 enable read back, R12 coalescing width
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v);
        chk("R7 enable implemented bits", v, 32'hBE00_00CB);
        wr(2'd3, 32'h0000_01FF);
        rd(2'd3, v);
        chk("R12 coal width", v, 32'h0000_00FF);

        // clear everything, enable bit 7 only, coal = 3
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0000_0080);
        wr(2'd3, 32'h3);
        idle(2);
        chk("R7 no irq when idle", {31'd0, irq}, 32'h0);

        // R8 delay 1 + 3*TICK
        step(32'h80, '0, 1'b0, 2'd0, '0);
        step(32'h40, '0, 1'b0, 2'd0, '0);   // disabled source, R7
        idle(3 * TICK - 1);
        chk("R8 irq not yet", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R8 irq after delay", {31'd0, irq}, 32'h1);

        // R11 drop after clear, then full reload
        wr(2'd0, 32'h80);
        idle(1);
        chk("R11 irq drops", {31'd0, irq}, 32'h0);
        chk("R7 disabled bit6 pending no irq", {31'd0, m_main[6]}, 32'h1);
        step(32'h80, '0, 1'b0, 2'd0, '0);
        idle(3 * TICK);
        chk("R11 reload still waits", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R11 reload fires", {31'd0, irq}, 32'h1);
        wr(2'd0, 32'hFFFF_FFFF);
        idle(1);

        // R9 zero delay
        wr(2'd3, 32'h0);
        step(32'h80, '0, 1'b0, 2'd0, '0);
        chk("R9 not same edge", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R9 immediate irq", {31'd0, irq}, 32'h1);
        wr(2'd0, 32'h80);
        idle(1);

        // R10 high-priority bypass with coal = 3
        wr(2'd3, 32'h3);
        wr(2'd1, 32'h8000_0000);
        step('0, 32'h4000_0000, 1'b0, 2'd0, '0);
        chk("R10 hp not same edge", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R10 hp bypass", {31'd0, irq}, 32'h1);
        wr(2'd2, 32'h4000_0000);
        idle(1);
        chk("R11 irq drops after hp clear", {31'd0, irq}, 32'h0);

        // R8 via receive summary
        step('0, 32'h0001_0000, 1'b0, 2'd0, '0);
        idle(3 * TICK);
        chk("R8 summary source waits", {31'd0, irq}, 32'h0);
        idle(1);
        chk("R8 summary source fires", {31'd0, irq}, 32'h1);

        // random phase with zero coalescing
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        idle(1);
        wr(2'd3, 32'h0);
        wr(2'd1, $urandom);
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sel;
            logic [31:0] s, dm, d;
            logic we;
            logic [1:0] a;
            sel = 2'($urandom % 4);
            chk_rd("R2 R4 R5 R7 random read", sel);
            chk("R9 R11 random irq", {31'd0, irq}, {31'd0, m_irq});
            s  = $urandom & $urandom & $urandom;
            dm = $urandom & $urandom & $urandom;
            we = ($urandom % 4) == 0;
            a  = 2'($urandom % 3);
            d  = $urandom;
            step(s, dm, we, a, d);
        end
        finish_run();
    end

endmodule